// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block turns one internal operand request into as many external bus cycles as the answering port needs. A request carries a byte count (one, two or four bytes), a direction, a start address and, for writes, the operand. The block drives a 16-bit external data bus. On every cycle it presents the address, a two-bit count of the operand bytes still left to move, and the data lanes. It then waits for a two-bit active-low acknowledge that tells it how wide the answering port is. Each cycle starts out assuming a 16-bit port. The acknowledge decides how many bytes really moved, and so how far the address and the remaining count advance.

Read bytes are collected across cycles into a 32-bit result that is right-justified, with the first byte sent (the most significant operand byte) ending up highest. When the remaining count reaches zero, a one-cycle completion pulse returns the result to the internal side. Write bytes are placed so that lanes 15–8 always carry the byte due at the current address. A byte port therefore never needs the low lanes.

Top module: `busz_sequencer`

## Requirements
- R1: After reset no bus cycle is active (`bus_cyc` low), `done` is low and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_ready` and `req_valid` are both high. In the next cycle `bus_cyc` is high, `bus_addr` equals the request address and `bus_siz` reports the full operand length.
- R3: While `bus_ack_n` is 11 (no acknowledge), the next cycle keeps `bus_cyc`, `bus_addr`, `bus_siz` and `bus_dout` unchanged.
- R4: A 16-bit acknowledge (`bus_ack_n` = 01) at an even address with two or more bytes left moves two bytes. The address advances by 2 and the remaining count drops by 2. For reads, lanes 15–8 give the earlier byte and lanes 7–0 the later one.
- R5: An 8-bit acknowledge (`bus_ack_n` = 10) moves one byte, taken from lanes 15–8, and advances the address by 1.
- R6: A 16-bit acknowledge at an odd address, or with only one byte left, moves one byte. At an odd address that byte is on lanes 7–0.
- R7: `bus_siz` gives the bytes still to move, with 01 = one, 10 = two, 11 = three and 00 = four. The `req_size` input uses the same code for the operand length: 01 byte, 10 word, 00 long-word.
- R8: On writes at an even address with two or more bytes left, `bus_dout` is {current byte, next byte}. Otherwise the current byte appears on both lanes.
- R9: After the acknowledge that moves the last byte, `done` is high for exactly one cycle, `bus_cyc` is low in that cycle, and `rdata` holds the read operand right-justified with the first-moved byte most significant and unused upper bytes zero.
- R10: `bus_ack_n` = 00 is handled exactly as a 16-bit acknowledge.
- R11: `req_valid` has no effect while a bus cycle is in progress. `req_ready` stays low, and the running operand completes with its own address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write operand, 0 = read |
| req_size | input | 2 | Operand length code (01 byte, 10 word, 00 long-word) |
| req_addr | input | ADDR_W | Start byte address of the operand |
| req_wdata | input | 32 | Write operand, right-justified |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read operand, valid with done |
| bus_cyc | output | 1 | External bus cycle in progress |
| bus_rw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | output | ADDR_W | Byte address of the current cycle (bit 0 = odd/even offset) |
| bus_siz | output | 2 | Operand bytes still to move, R7 code |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| bus_ack_n | input | 2 | Active-low acknowledge and port width (11 wait, 10 byte port, 01/00 word port) |

## Verification
The bench builds the sequencer with `ADDR_W` set to 16. This lets a 256-byte array, indexed by the low address bits, act as both a byte port and a word port while still driving a full-width address path. With that model, every start alignment can be reached: long-words at odd addresses that split into one, two and one byte, byte ports that step four times, and single bytes at odd offsets. Waits can be placed before any acknowledge, and the bench can raise a competing request during a transfer.

// File: rtl/busz_pkg.sv
package busz_pkg;

  localparam int OPND_BYTES = 4;
  localparam int OPND_W     = 8 * OPND_BYTES;
  localparam int LANE_W     = 16;
  localparam int CNT_W      = $clog2(OPND_BYTES + 1);

  typedef enum logic [1:0] {
    ACK_P16_ALT = 2'b00,
    ACK_P16     = 2'b01,
    ACK_P8      = 2'b10,
    ACK_WAIT    = 2'b11
  } ack_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } seq_st_e;

endpackage

// File: rtl/busz_step.sv
module busz_step
  import busz_pkg::*;
(
  input  logic [1:0]       ack_n,
  input  logic             odd,
  input  logic [CNT_W-1:0] rem,
  output logic             acked,
  output logic             port8,
  output logic             wide,
  output logic             lane_lo,
  output logic [CNT_W-1:0] step
);

  always_comb begin
    acked   = (ack_n != ACK_WAIT);
    port8   = (ack_n == ACK_P8);
    wide    = acked && !port8 && !odd && (rem > CNT_W'(1));
    lane_lo = acked && !port8 && odd;
    step    = wide ? CNT_W'(2) : CNT_W'(1);
  end

endmodule

// File: rtl/busz_wr_lanes.sv
module busz_wr_lanes
  import busz_pkg::*;
(
  input  logic [OPND_W-1:0] wsh,
  input  logic              odd,
  input  logic [CNT_W-1:0]  rem,
  output logic [LANE_W-1:0] dout
);

  logic       pair;
  logic [7:0] cur_b;
  logic [7:0] nxt_b;

  always_comb begin
    cur_b = wsh[OPND_W-1 -: 8];
    nxt_b = wsh[OPND_W-9 -: 8];
    pair  = !odd && (rem > CNT_W'(1));
    dout  = pair ? {cur_b, nxt_b} : {cur_b, cur_b};
  end

endmodule

// File: rtl/busz_rd_gather.sv
module busz_rd_gather
  import busz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              wide,
  input  logic              lane_lo,
  input  logic [LANE_W-1:0] din,
  output logic [OPND_W-1:0] acc
);

  logic [OPND_W-1:0] acc_nxt;
  logic              acc_en;
  logic [7:0]        one_b;

  always_comb begin
    one_b   = lane_lo ? din[7:0] : din[15:8];
    acc_en  = clr || take;
    acc_nxt = acc;
    if (clr)
      acc_nxt = '0;
    else if (take && wide)
      acc_nxt = {acc[OPND_W-LANE_W-1:0], din};
    else if (take)
      acc_nxt = {acc[OPND_W-9:0], one_b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc <= '0;
    else if (acc_en)
      acc <= acc_nxt;
  end

endmodule

// File: rtl/busz_sequencer.sv
module busz_sequencer
  import busz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [OPND_W-1:0] req_wdata,
  output logic              done,
  output logic [OPND_W-1:0] rdata,
  output logic              bus_cyc,
  output logic              bus_rw,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [LANE_W-1:0] bus_dout,
  input  logic [LANE_W-1:0] bus_din,
  input  logic [1:0]        bus_ack_n
);

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [OPND_W-1:0] wsh_q, wsh_d;
  logic              wr_q, wr_d;
  logic              done_q, done_d;
  logic              ctl_en;

  logic              acked, port8, wide, lane_lo;
  logic [CNT_W-1:0]  step;
  logic [CNT_W-1:0]  req_cnt;
  logic [CNT_W-1:0]  rem_after;
  logic              accept, fire;

  busz_step u_step (
    .ack_n   (bus_ack_n),
    .odd     (addr_q[0]),
    .rem     (rem_q),
    .acked   (acked),
    .port8   (port8),
    .wide    (wide),
    .lane_lo (lane_lo),
    .step    (step)
  );

  busz_wr_lanes u_wr (
    .wsh  (wsh_q),
    .odd  (addr_q[0]),
    .rem  (rem_q),
    .dout (bus_dout)
  );

  busz_rd_gather u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .take    (fire && !wr_q),
    .wide    (wide),
    .lane_lo (lane_lo),
    .din     (bus_din),
    .acc     (rdata)
  );

  always_comb begin
    accept    = (st_q == ST_IDLE) && req_valid;
    fire      = (st_q == ST_BUS) && acked;
    req_cnt   = (req_size == 2'b00) ? CNT_W'(OPND_BYTES) : CNT_W'(req_size);
    rem_after = rem_q - step;

    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    wsh_d  = wsh_q;
    wr_d   = wr_q;
    done_d = 1'b0;
    ctl_en = 1'b0;

    if (accept) begin
      ctl_en = 1'b1;
      st_d   = ST_BUS;
      addr_d = req_addr;
      rem_d  = req_cnt;
      wr_d   = req_write;
      case (req_size)
        2'b01:   wsh_d = {req_wdata[7:0], 24'h0};
        2'b10:   wsh_d = {req_wdata[15:0], 16'h0};
        2'b11:   wsh_d = {req_wdata[23:0], 8'h0};
        default: wsh_d = req_wdata;
      endcase
    end else if (fire) begin
      ctl_en = 1'b1;
      addr_d = addr_q + ADDR_W'(step);
      rem_d  = rem_after;
      wsh_d  = wide ? {wsh_q[OPND_W-17:0], 16'h0} : {wsh_q[OPND_W-9:0], 8'h0};
      if (rem_after == '0) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      wsh_q  <= '0;
      wr_q   <= 1'b0;
    end else if (ctl_en) begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      wsh_q  <= wsh_d;
      wr_q   <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done_q <= 1'b0;
    else
      done_q <= done_d;
  end

  assign req_ready = (st_q == ST_IDLE);
  assign bus_cyc   = (st_q == ST_BUS);
  assign bus_rw    = !wr_q;
  assign bus_addr  = addr_q;
  assign bus_siz   = rem_q[1:0];
  assign done      = done_q;

endmodule

// File: rtl/busz_seq_chk.sv
module busz_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              bus_cyc,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic [15:0]       bus_dout,
  input logic [1:0]        bus_ack_n
);

  assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && bus_cyc));

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack_n == 2'b11) |=>
      (bus_cyc && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout)));

  assert_wide_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack_n == 2'b01 && !bus_addr[0] && bus_siz == 2'b00) |=>
      (bus_cyc && bus_siz == 2'b10 && bus_addr == $past(bus_addr) + ADDR_W'(2)));

  assert_narrow_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack_n == 2'b10 && bus_siz != 2'b01) |=>
      (bus_cyc && bus_addr == $past(bus_addr) + ADDR_W'(1)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_cyc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_cyc && $past(bus_cyc)));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack_n == 2'b11) |=> !req_ready);

endmodule

bind busz_sequencer busz_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .bus_cyc   (bus_cyc),
  .bus_addr  (bus_addr),
  .bus_siz   (bus_siz),
  .bus_dout  (bus_dout),
  .bus_ack_n (bus_ack_n)
);

// File: tb/busz_sequencer_tb.sv
module busz_sequencer_tb_top;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          done;
  logic [31:0]   rdata;
  logic          bus_cyc;
  logic          bus_rw;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic [15:0]   bus_dout;
  logic [15:0]   bus_din = '0;
  logic [1:0]    bus_ack_n = 2'b11;

  always #2 clk = ~clk;

  busz_sequencer #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .bus_cyc(bus_cyc),
    .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [0:255];
  int          ncyc;
  logic [1:0]  siz_log  [0:7];
  logic [15:0] addr_log [0:7];
  logic [15:0] dout_log [0:7];
  logic [31:0] got_rd;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int a, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[23:0], mem[(a + i) & 255]};
    return v;
  endfunction

  // Bus model: byte port or word port, optional waits before each acknowledge.
  task automatic run_op(input bit wr, input logic [1:0] sz, input int a,
                        input logic [31:0] wd, input bit p8, input bit alt00,
                        input int waits, input bit noise);
    int w;
    bit was_wait;
    logic [15:0] ha, hd;
    logic [1:0]  hs;
    int ia;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = AW'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = 16'h00EE; req_wdata = 32'hDEADBEEF; req_size = 2'b01;
    ncyc = 0; w = waits; was_wait = 1'b0;
    for (int g = 0; g < 60; g++) begin
      if (done) begin
        got_rd = rdata;
        break;
      end
      if (bus_cyc) begin
        if (was_wait) begin
          chk(bus_addr == ha && bus_siz == hs && bus_dout == hd, "R3",
              "outputs held in wait", {bus_addr, bus_dout}, {ha, hd});
        end
        if (noise) begin
          req_valid = 1'b1;
          chk(req_ready == 1'b0, "R11", "ready low while busy", 32'(req_ready), 32'd0);
        end
        if (w > 0) begin
          bus_ack_n = 2'b11;
          ha = bus_addr; hs = bus_siz; hd = bus_dout;
          was_wait = 1'b1;
          w--;
        end else begin
          was_wait = 1'b0;
          ia = int'(bus_addr[7:0]);
          if (ncyc < 8) begin
            siz_log[ncyc] = bus_siz; addr_log[ncyc] = bus_addr; dout_log[ncyc] = bus_dout;
          end
          ncyc++;
          bus_ack_n = p8 ? 2'b10 : (alt00 ? 2'b00 : 2'b01);
          if (!wr) begin
            if (p8) bus_din = {mem[ia], 8'hEE};
            else    bus_din = {mem[ia & 254], mem[ia | 1]};
          end else begin
            if (p8) mem[ia] = bus_dout[15:8];
            else if (ia[0]) mem[ia] = bus_dout[7:0];
            else begin
              mem[ia] = bus_dout[15:8];
              if (bus_siz != 2'b01) mem[(ia + 1) & 255] = bus_dout[7:0];
            end
          end
          w = waits;
        end
      end else begin
        bus_ack_n = 2'b11;
      end
      @(negedge clk);
    end
    bus_ack_n = 2'b11;
    req_valid = 1'b0;
    chk(done == 1'b1, "R9", "done seen", 32'(done), 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done lasts one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk(bus_cyc == 1'b0, "R1", "bus_cyc after reset", 32'(bus_cyc), 32'd0);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
  endtask

  task automatic t_long_word_port;
    logic [31:0] e = exp_read(16'h40, 4);
    run_op(1'b0, 2'b00, 16'h40, '0, 1'b0, 1'b0, 0, 1'b0);
    chk(ncyc == 2, "R4", "long on word port cycles", 32'(ncyc), 32'd2);
    chk(addr_log[0] == 16'h40 && siz_log[0] == 2'b00, "R2", "first cycle addr/siz",
        {addr_log[0], 14'h0, siz_log[0]}, {16'h40, 16'h0});
    chk(addr_log[1] == 16'h42 && siz_log[1] == 2'b10, "R7", "second cycle siz 10",
        {addr_log[1], 14'h0, siz_log[1]}, {16'h42, 16'h2});
    chk(got_rd == e, "R9", "long read data", got_rd, e);
  endtask

  task automatic t_long_byte_port;
    logic [31:0] e = exp_read(16'h50, 4);
    run_op(1'b0, 2'b00, 16'h50, '0, 1'b1, 1'b0, 0, 1'b0);
    chk(ncyc == 4, "R5", "long on byte port cycles", 32'(ncyc), 32'd4);
    chk({siz_log[0], siz_log[1], siz_log[2], siz_log[3]} == 8'b00_11_10_01, "R7",
        "siz sequence 4,3,2,1", 32'({siz_log[0], siz_log[1], siz_log[2], siz_log[3]}),
        32'b00_11_10_01);
    chk(addr_log[3] == 16'h53, "R5", "address steps by one", 32'(addr_log[3]), 32'h53);
    chk(got_rd == e, "R5", "byte port read data", got_rd, e);
  endtask

  task automatic t_long_odd;
    logic [31:0] e = exp_read(16'h61, 4);
    run_op(1'b0, 2'b00, 16'h61, '0, 1'b0, 1'b0, 0, 1'b0);
    chk(ncyc == 3, "R6", "odd long cycles", 32'(ncyc), 32'd3);
    chk(addr_log[1] == 16'h62 && addr_log[2] == 16'h64, "R6", "odd long addresses",
        {addr_log[1], addr_log[2]}, {16'h62, 16'h64});
    chk({siz_log[0], siz_log[1], siz_log[2]} == 6'b00_11_01, "R7", "odd long siz",
        32'({siz_log[0], siz_log[1], siz_log[2]}), 32'b00_11_01);
    chk(got_rd == e, "R6", "odd long data via low lanes", got_rd, e);
  endtask

  task automatic t_byte_read;
    logic [31:0] e = exp_read(16'h70, 1);
    run_op(1'b0, 2'b01, 16'h70, '0, 1'b0, 1'b0, 0, 1'b0);
    chk(ncyc == 1 && siz_log[0] == 2'b01, "R7", "byte read one cycle siz 01",
        32'(ncyc), 32'd1);
    chk(got_rd == e, "R9", "byte read right-justified", got_rd, e);
  endtask

  task automatic t_word_write_byte_port;
    run_op(1'b1, 2'b10, 16'h80, 32'h0000A1B2, 1'b1, 1'b0, 0, 1'b0);
    chk(ncyc == 2, "R5", "word write byte port cycles", 32'(ncyc), 32'd2);
    chk(dout_log[0] == 16'hA1B2, "R8", "pair lanes", 32'(dout_log[0]), 32'hA1B2);
    chk(dout_log[1] == 16'hB2B2, "R8", "last byte duplicated", 32'(dout_log[1]), 32'hB2B2);
    chk({mem[8'h80], mem[8'h81]} == 16'hA1B2, "R8", "memory after write",
        32'({mem[8'h80], mem[8'h81]}), 32'hA1B2);
  endtask

  task automatic t_long_write_odd_waits;
    run_op(1'b1, 2'b00, 16'h91, 32'h11223344, 1'b0, 1'b0, 2, 1'b0);
    chk(ncyc == 3, "R6", "odd long write cycles", 32'(ncyc), 32'd3);
    chk(dout_log[0] == 16'h1111 && dout_log[1] == 16'h2233 && dout_log[2] == 16'h4444,
        "R8", "odd long write lanes", {dout_log[0], dout_log[2]}, {16'h1111, 16'h4444});
    chk({mem[8'h91], mem[8'h92], mem[8'h93], mem[8'h94]} == 32'h11223344, "R8",
        "memory after odd write",
        {mem[8'h91], mem[8'h92], mem[8'h93], mem[8'h94]}, 32'h11223344);
  endtask

  task automatic t_ack00;
    logic [31:0] e = exp_read(16'hA0, 2);
    run_op(1'b0, 2'b10, 16'hA0, '0, 1'b0, 1'b1, 0, 1'b0);
    chk(ncyc == 1, "R10", "ack 00 moves two bytes", 32'(ncyc), 32'd1);
    chk(got_rd == e, "R10", "ack 00 word data", got_rd, e);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] e = exp_read(16'hB0, 4);
    run_op(1'b0, 2'b00, 16'hB0, '0, 1'b0, 1'b0, 1, 1'b1);
    chk(ncyc == 2 && addr_log[1] == 16'hB2, "R11", "busy op unchanged",
        32'(addr_log[1]), 32'hB2);
    chk(got_rd == e, "R11", "busy op data", got_rd, e);
    @(negedge clk);
    chk(bus_cyc == 1'b0, "R11", "no cycle from ignored request", 32'(bus_cyc), 32'd0);
  endtask

  task automatic t_byte_write_odd;
    run_op(1'b1, 2'b01, 16'hC3, 32'h0000005A, 1'b0, 1'b0, 0, 1'b0);
    chk(dout_log[0] == 16'h5A5A, "R8", "odd byte on both lanes", 32'(dout_log[0]), 32'h5A5A);
    chk(mem[8'hC3] == 8'h5A, "R6", "odd byte written from low lanes",
        32'(mem[8'hC3]), 32'h5A);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long_word_port();
    t_long_byte_port();
    t_long_odd();
    t_byte_read();
    t_word_write_byte_port();
    t_long_write_odd_waits();
    t_ack00();
    t_busy_ignore();
    t_byte_write_odd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule